// File: doc/BRIEF.md
# Delay-and-Sum Direction Search Engine

This block estimates where a sound comes from, using an array of eight microphones. Samples arrive on a single stream, and each sample is tagged with its channel number. Once software launches a search, every enabled channel fills a circular capture buffer. A programmable rate sets the decimation: a channel stores one sample and then skips that many samples before it stores the next. When every enabled buffer is full, the engine steps through 16 candidate directions. For each direction it reads each buffer at a read index shifted by a per-direction, per-channel offset, adds the aligned samples, and scales the sum by an arithmetic right shift. It then adds the magnitude of that scaled value into a saturating energy figure for the direction.

Software programs the offset table and the control fields through a simple register port, writes the start bit and waits. The start bit stays set for the whole search and clears itself at the end. At that point a ready flag is set and the 16 energies can be read back. Software picks the winning direction. The ready flag is cleared by writing 1 to it and can be masked from the interrupt pin. A path-reset bit aborts a search at any time.

Top module: `dsum_search`

## Requirements
- R1: After reset, CTRL (address 0x20) reads 0x0000FF00: start 0, shift 0, all eight channels enabled, rate 0. STATUS (0x21) reads 0, irq is 0 and every energy register reads 0.
- R2: Offset word address {dir[3:0], w} (0x00 to 0x1F) holds four 8-bit read offsets. Byte k (bits 8k+7:8k) belongs to channel 4w+k. An offset is applied modulo the buffer depth of 64.
- R3: Writing CTRL with bit 0 set and bit 1 clear launches a search from idle. CTRL bit 0 then reads 1 until the search ends, and then clears itself without a software write.
- R4: CTRL fields are shift in bits 7:4, channel enable in bits 15:8 and rate in bits 19:16. Each enabled channel stores its first sample after launch, then one sample in every rate+1 of its own samples, until 64 are stored. Later samples, and samples of disabled channels, are ignored, and a disabled channel need not fill.
- R5: Energy register 0x30+d reads E[d], the sum over t = 0..63 of |(S >>> shift)|, where S is the sum over enabled channels c of buf[c][(t + off[d][c]) mod 64]. A disabled channel contributes zero. Energies hold until the next search or path reset.
- R6: An energy that would exceed 2^24-1 reads 0xFFFFFF.
- R7: Completion sets STATUS bit 0. Writing 1 to that bit clears it, and writing 0 leaves it unchanged.
- R8: irq is 1 exactly when STATUS bit 0 is 1 and MASK (0x22) bit 0 is 0.
- R9: Writing CTRL with bit 1 set aborts any search. It clears the start bit and all energies, leaves STATUS unchanged, and no completion follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample strobe |
| smp_ch | input | 3 | Channel tag of the sample |
| smp_data | input | 16 | Signed sample value |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| irq | output | 1 | Search-ready interrupt |

## Verification
On every cycle the assertions check four things: no capture counter passes the buffer depth, the start bit stays high for as long as the engine is not idle, the summing phase runs only while every enabled buffer is full, and the ready flag rises only out of the summing phase. They also check that the energies stay fixed while the engine is idle. Only the bench scenarios can show that the energy values themselves are correct. This covers offset steering with wrap-around, decimated capture, masked channels, saturation, the interrupt mask and the abort path, all compared against a model computed in the bench.

// File: rtl/dsum_pkg.sv
package dsum_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_FILL = 2'd1,
        PH_SUM  = 2'd2
    } phase_e;

    localparam logic [5:0] A_CTRL = 6'h20;
    localparam logic [5:0] A_STAT = 6'h21;
    localparam logic [5:0] A_MASK = 6'h22;
endpackage

// File: rtl/dsum_offsets.sv
module dsum_offsets #(
    parameter int NDIR = 16,
    parameter int NCH  = 8,
    parameter int OFW  = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_i,
    input  logic [$clog2(NDIR)-1:0]     wr_dir_i,
    input  logic [$clog2(NCH*OFW/32)>0 ? $clog2(NCH*OFW/32)-1 : 0 : 0] wr_word_i,
    input  logic [31:0]                 wr_dat_i,
    input  logic [$clog2(NDIR)-1:0]     sel_i,
    output logic [NCH*OFW-1:0]          off_o
);
    localparam int NW = NCH * OFW / 32;

    logic [NDIR-1:0][NW-1:0][31:0] tab_d, tab_q;

    always_comb begin
        tab_d = tab_q;
        if (wr_i) tab_d[wr_dir_i][wr_word_i] = wr_dat_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tab_q <= '0;
        else        tab_q <= tab_d;
    end

    assign off_o = tab_q[sel_i];
endmodule

// File: rtl/dsum_capture.sv
module dsum_capture #(
    parameter int NCH   = 8,
    parameter int DEPTH = 64,
    parameter int SW    = 16,
    parameter int RW    = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              clr_i,
    input  logic                              arm_i,
    input  logic [NCH-1:0]                    en_i,
    input  logic [RW-1:0]                     rate_i,
    input  logic                              vld_i,
    input  logic [$clog2(NCH)-1:0]            ch_i,
    input  logic [SW-1:0]                     dat_i,
    input  logic [NCH*$clog2(DEPTH)-1:0]      rd_idx_i,
    output logic [NCH*SW-1:0]                 rd_dat_o,
    output logic [NCH-1:0]                    full_o
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(NCH);
    localparam logic [AW:0] FULLV = (AW+1)'(DEPTH);

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic [AW:0]   cnt_d, cnt_q;
        logic [RW-1:0] skip_d, skip_q;
        logic [SW-1:0] mem_q [DEPTH];
        logic          hit, take;

        always_comb begin
            hit    = arm_i && vld_i && en_i[g] && (ch_i == CW'(g)) && (cnt_q != FULLV);
            take   = hit && (skip_q == '0);
            cnt_d  = cnt_q;
            skip_d = skip_q;
            if (clr_i) begin
                cnt_d  = '0;
                skip_d = '0;
            end else if (take) begin
                cnt_d  = cnt_q + 1'b1;
                skip_d = rate_i;
            end else if (hit) begin
                skip_d = skip_q - 1'b1;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cnt_q  <= '0;
                skip_q <= '0;
            end else begin
                cnt_q  <= cnt_d;
                skip_q <= skip_d;
            end
        end

        always_ff @(posedge clk) begin
            if (take && !clr_i) mem_q[cnt_q[AW-1:0]] <= dat_i;
        end

        assign rd_dat_o[g*SW +: SW] = mem_q[rd_idx_i[g*AW +: AW]];
        assign full_o[g]            = !en_i[g] || (cnt_q == FULLV);

        // R4
        fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_q <= FULLV);
    end
endmodule

// File: rtl/dsum_search.sv
module dsum_search #(
    parameter int NCH   = 8,
    parameter int NDIR  = 16,
    parameter int DEPTH = 64,
    parameter int SW    = 16,
    parameter int OFW   = 8,
    parameter int RW    = 4,
    parameter int SHW   = 4,
    parameter int ACCW  = 24
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        smp_valid,
    input  logic [2:0]  smp_ch,
    input  logic [15:0] smp_data,
    input  logic        reg_wr,
    input  logic [5:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq
);
    import dsum_pkg::*;

    localparam int AW   = $clog2(DEPTH);
    localparam int DW   = $clog2(NDIR);
    localparam int SUMW = SW + $clog2(NCH);

    typedef struct packed {
        phase_e                     ph;
        logic                       start;
        logic                       ready;
        logic                       mask;
        logic [SHW-1:0]             shift;
        logic [NCH-1:0]             en;
        logic [RW-1:0]              rate;
        logic [DW-1:0]              dir;
        logic [AW-1:0]              t;
        logic [NDIR-1:0][ACCW-1:0]  acc;
    } st_t;

    st_t s_d, s_q;

    logic                   wr_ctrl, launch, prst, off_wr;
    logic [NCH*OFW-1:0]     off;
    logic [NCH*AW-1:0]      rd_idx;
    logic [NCH*SW-1:0]      rd_dat;
    logic [NCH-1:0]         full;
    logic signed [SUMW-1:0] sum, scaled;
    logic [SUMW-1:0]        mag;
    logic [ACCW:0]          nxt;
    logic [ACCW-1:0]        nxt_sat;

    assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);
    assign prst    = wr_ctrl && reg_wdata[1];
    assign launch  = wr_ctrl && reg_wdata[0] && !reg_wdata[1] && (s_q.ph == PH_IDLE);
    assign off_wr  = reg_wr && !reg_addr[5];

    dsum_offsets #(.NDIR(NDIR), .NCH(NCH), .OFW(OFW)) u_tab (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (off_wr),
        .wr_dir_i (reg_addr[4:1]),
        .wr_word_i(reg_addr[0]),
        .wr_dat_i (reg_wdata),
        .sel_i    (s_q.dir),
        .off_o    (off)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_idx
        assign rd_idx[c*AW +: AW] = s_q.t + off[c*OFW +: AW];
    end

    dsum_capture #(.NCH(NCH), .DEPTH(DEPTH), .SW(SW), .RW(RW)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (launch || prst),
        .arm_i   (s_q.ph == PH_FILL),
        .en_i    (s_q.en),
        .rate_i  (s_q.rate),
        .vld_i   (smp_valid),
        .ch_i    (smp_ch),
        .dat_i   (smp_data),
        .rd_idx_i(rd_idx),
        .rd_dat_o(rd_dat),
        .full_o  (full)
    );

    always_comb begin
        sum = '0;
        for (int c = 0; c < NCH; c++) begin
            if (s_q.en[c]) sum = sum + SUMW'($signed(rd_dat[c*SW +: SW]));
        end
        scaled  = sum >>> s_q.shift;
        mag     = scaled[SUMW-1] ? SUMW'(-scaled) : SUMW'(scaled);
        nxt     = {1'b0, s_q.acc[s_q.dir]} + (ACCW+1)'(mag);
        nxt_sat = nxt[ACCW] ? '1 : nxt[ACCW-1:0];
    end

    always_comb begin
        s_d = s_q;
        if (wr_ctrl) begin
            s_d.shift = reg_wdata[7:4];
            s_d.en    = reg_wdata[15:8];
            s_d.rate  = reg_wdata[19:16];
        end
        if (reg_wr && reg_addr == A_MASK) s_d.mask = reg_wdata[0];
        if (reg_wr && reg_addr == A_STAT && reg_wdata[0]) s_d.ready = 1'b0;
        unique case (s_q.ph)
            PH_IDLE: if (launch) begin
                s_d.start = 1'b1;
                s_d.ph    = PH_FILL;
            end
            PH_FILL: if (&full) begin
                s_d.ph  = PH_SUM;
                s_d.dir = '0;
                s_d.t   = '0;
                s_d.acc = '0;
            end
            PH_SUM: begin
                s_d.acc[s_q.dir] = nxt_sat;
                s_d.t = s_q.t + 1'b1;
                if (s_q.t == AW'(DEPTH-1)) begin
                    s_d.dir = s_q.dir + 1'b1;
                    if (s_q.dir == DW'(NDIR-1)) begin
                        s_d.ph    = PH_IDLE;
                        s_d.start = 1'b0;
                        s_d.ready = 1'b1;
                    end
                end
            end
            default: s_d.ph = PH_IDLE;
        endcase
        if (prst) begin
            s_d.ph    = PH_IDLE;
            s_d.start = 1'b0;
            s_d.dir   = '0;
            s_d.t     = '0;
            s_d.acc   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.ph    <= PH_IDLE;
            s_q.en    <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == A_CTRL)
            reg_rdata = 32'({s_q.rate, s_q.en, s_q.shift, 3'b000, s_q.start});
        else if (reg_addr == A_STAT)
            reg_rdata = 32'(s_q.ready);
        else if (reg_addr == A_MASK)
            reg_rdata = 32'(s_q.mask);
        else if (reg_addr[5:4] == 2'b11)
            reg_rdata = 32'(s_q.acc[reg_addr[3:0]]);
    end

    assign irq = s_q.ready && !s_q.mask;

    // R3
    start_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ph != PH_IDLE) |-> s_q.start);
    // R4
    sum_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ph == PH_SUM) |-> (&full));
    // R7
    ready_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.ready) |-> ($past(s_q.ph) == PH_SUM));
    // R5
    energy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ph == PH_IDLE && $past(s_q.ph) == PH_IDLE && !$past(prst)) |-> $stable(s_q.acc));
endmodule

// File: tb/sim_dsum_search.sv
module sim_dsum_search;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [2:0]  smp_ch = '0;
    logic [15:0] smp_data = '0;
    logic        reg_wr = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;

    localparam longint MAXE = 64'd16777215;

    logic signed [15:0] strm  [8][256];
    logic signed [15:0] buf_m [8][64];
    logic [7:0]         off_m [16][8];
    logic [7:0]         en_m;
    int                 shift_m;

    always #10 clk = ~clk;

    dsum_search u0 (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ch(smp_ch),
        .smp_data(smp_data), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    function automatic longint exp_energy(input int d);
        longint acc = 0;
        for (int t = 0; t < 64; t++) begin
            int s = 0;
            for (int c = 0; c < 8; c++)
                if (en_m[c]) s += int'(buf_m[c][(t + int'(off_m[d][c])) % 64]);
            s = s >>> shift_m;
            if (s < 0) s = -s;
            acc += s;
            if (acc > MAXE) acc = MAXE;
        end
        return acc;
    endfunction

    task automatic load_offsets(input bit rnd);
        for (int d = 0; d < 16; d++)
            for (int c = 0; c < 8; c++)
                off_m[d][c] = rnd ? 8'($urandom) : 8'((d * (c + 1)) % 8);
        for (int d = 0; d < 16; d++)
            for (int w = 0; w < 2; w++)
                wr(6'(d * 2 + w), {off_m[d][4*w+3], off_m[d][4*w+2], off_m[d][4*w+1], off_m[d][4*w]});
    endtask

    task automatic feed(input int rounds, input int lim);
        for (int k = 0; k < rounds; k++)
            for (int c = 0; c < 8; c++) begin
                @(negedge clk);
                smp_valid = 1'b1;
                smp_ch    = 3'(c);
                smp_data  = (k < lim) ? strm[c][k] : 16'sh1234;
            end
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic run_search(input int sh, input logic [7:0] en, input int rate, input bit sat);
        logic [31:0] v;
        int lim;
        for (int c = 0; c < 8; c++)
            for (int k = 0; k < 256; k++)
                strm[c][k] = sat ? 16'sh8000 : 16'($urandom);
        en_m = en; shift_m = sh;
        lim = 64 * (rate + 1);
        wr(6'h20, {12'd0, 4'(rate), en, 4'(sh), 4'b0001});
        rd(6'h20, v);
        check(v[0] == 1'b1, "R3 start set during search", v[0], 1);
        feed(lim + 3, lim);
        for (int c = 0; c < 8; c++)
            for (int i = 0; i < 64; i++) buf_m[c][i] = strm[c][i * (rate + 1)];
        for (int n = 0; n < 4000; n++) begin
            rd(6'h20, v);
            if (v[0] == 1'b0) break;
        end
        check(v[0] == 1'b0, "R3 start self-clears", v[0], 0);
    endtask

    task automatic check_energies(input string req);
        logic [31:0] v;
        for (int d = 0; d < 16; d++) begin
            longint e = exp_energy(d);
            rd(6'(48 + d), v);
            check(longint'(v) == e, req, v, e);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(6'h20, v); check(v == 32'h0000FF00, "R1 CTRL reset", v, 32'h0000FF00);
        rd(6'h21, v); check(v == 0, "R1 STATUS reset", v, 0);
        check(irq == 1'b0, "R1 irq reset", irq, 0);
        rd(6'h35, v); check(v == 0, "R1 energy reset", v, 0);

        // R2 R5 random offsets with wrap, all channels, no decimation
        load_offsets(1'b1);
        run_search(3, 8'hFF, 0, 1'b0);
        check_energies("R2 R5 energy random offsets");
        rd(6'h21, v); check(v[0] == 1'b1, "R7 ready after search", v[0], 1);
        check(irq == 1'b1, "R8 irq unmasked", irq, 1);

        // R7 write 0 no effect, write 1 clears
        wr(6'h21, 32'h0);
        rd(6'h21, v); check(v[0] == 1'b1, "R7 write 0 keeps ready", v[0], 1);
        wr(6'h21, 32'h1);
        rd(6'h21, v); check(v[0] == 1'b0, "R7 W1C clears ready", v[0], 0);
        check(irq == 1'b0, "R8 irq after clear", irq, 0);

        // R4 R5 masked channels with decimation, interrupt masked
        wr(6'h22, 32'h1);
        load_offsets(1'b0);
        run_search(5, 8'h5A, 2, 1'b0);
        check_energies("R4 R5 energy decimated subset");
        rd(6'h21, v); check(v[0] == 1'b1, "R7 ready masked run", v[0], 1);
        check(irq == 1'b0, "R8 irq masked", irq, 0);
        wr(6'h22, 32'h0);
        @(negedge clk);
        check(irq == 1'b1, "R8 irq after unmask", irq, 1);
        wr(6'h21, 32'h1);

        // R9 path reset mid-capture
        for (int c = 0; c < 8; c++)
            for (int k = 0; k < 256; k++) strm[c][k] = 16'($urandom);
        wr(6'h20, 32'h0000FF01);
        feed(10, 10);
        wr(6'h20, 32'h0000FF02);
        rd(6'h20, v); check(v[0] == 1'b0, "R9 reset clears start", v[0], 0);
        feed(80, 80);
        repeat (1200) @(negedge clk);
        rd(6'h21, v); check(v[0] == 1'b0, "R9 no completion after abort", v[0], 0);
        rd(6'h30, v); check(v == 0, "R9 energy dir0 cleared", v, 0);
        rd(6'h37, v); check(v == 0, "R9 energy dir7 cleared", v, 0);

        // R6 saturation with full-scale negative samples
        load_offsets(1'b1);
        run_search(0, 8'hFF, 1, 1'b1);
        rd(6'h3A, v); check(v == 32'hFFFFFF, "R6 saturated energy", v, 32'hFFFFFF);
        check_energies("R6 energies at saturation");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule